// File: doc/BRIEF.md
# Serial-In Latched Output Register

This block turns a serial bit stream into eight parallel channel-drive enables. Bits enter a shift chain on each rising edge of a serial clock. A level-sensitive strobe copies the chain into a bank of output latches. An active-high output-off input gates the latched pattern onto the drive lines. The last shift stage is brought out as serial data out, so a second device fed from it extends the channel count.

A separate protection block supplies one disable line per channel and one global disable. Either of them forces the affected outputs off. Clear does not act on the outputs directly. It replaces the shifted-in bit with an all-off pattern, but only at a serial clock edge, and that pattern reaches the outputs only through the strobe.

All inputs are synchronous to the system clock `clk`. The serial clock is sampled on `clk` and its rising edge is detected there, so one serial bit needs two system clock cycles. At a 100 MHz system clock this gives far more than the required 3.3 MHz serial rate.

Top module: `slr_top`

## Requirements
- R1: A rising edge of `sclk` is recognised at the first `clk` edge that samples `sclk` high after it was low. At that `clk` edge the shift chain moves one place: `sdi` enters stage 0 and stage i moves to stage i+1. Without such an edge the chain holds.
- R2: `sdo` always shows stage 7. A bit shifted in therefore appears on `sdo` after 8 serial edges, which allows devices to be cascaded.
- R3: If `clear` is high at a recognised serial edge, all eight stages become 0. A high `clear` with no serial edge changes neither the chain nor the outputs.
- R4: While `strobe` is high, each `clk` edge copies the shift chain into the output latches. A cleared pattern therefore reaches `drive` only after a strobe.
- R5: While `strobe` is low, the output latches hold, whatever is shifted in.
- R6: `drive[i]` equals latch bit i when `outOff` is low. All `drive` bits are 0 when `outOff` is high, and this takes effect without a clock edge.
- R7: `drive[i]` is 0 while `chanFault[i]` is high, and all `drive` bits are 0 while `allFault` is high. Other channels are unaffected.
- R8: Asserting `rstN` low clears the shift chain and the output latches at once, without waiting for a clock edge. `drive` and `sdo` then read 0.
- R9: The block accepts back-to-back serial bits with `sclk` high for one `clk` cycle and low for one `clk` cycle. That is 50 MHz at a 100 MHz `clk`, above the 3.3 MHz minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled on clk |
| sdi | input | 1 | Serial data in |
| clear | input | 1 | Load all-off at the next serial edge |
| strobe | input | 1 | Level-sensitive latch load |
| outOff | input | 1 | High forces every drive line off |
| chanFault | input | 8 | Per-channel disable from the protection block |
| allFault | input | 1 | Global disable from the protection block |
| drive | output | 8 | Channel drive enables |
| sdo | output | 1 | Serial data out (stage 7) |

## Verification
Results arrive at different times:
- A serial bit is visible on `sdo` right after the `clk` edge that first samples `sclk` high.
- A strobe moves the chain to `drive` at the `clk` edge that samples `strobe` high.
- With `strobe` held high, a new bit reaches `drive` one `clk` edge after it was shifted.
- `outOff`, `chanFault` and `allFault` act on `drive` combinationally, in the same cycle.

The bench drives inputs on falling edges and samples on the following falling edge, or shortly after a combinational change. Its reference model advances only at the points where the requirements say a result is due.

// File: rtl/slr_pkg.sv
package slr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // serial edge recognised this cycle
    logic clrLoad;   // load all-off instead of shifting
    logic latchEn;   // copy shift chain into output latches
  } slr_ctrl_t;
endpackage

// File: rtl/slr_ctrl.sv
module slr_ctrl
  import slr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      clear,
  input  logic      strobe,
  output slr_ctrl_t ctrl
);
  logic sclkPrev;

  // Reset high so that sclk already high at reset release is not taken as an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclk;
  end

  always_comb begin
    ctrl.shiftEn = sclk & ~sclkPrev;
    ctrl.clrLoad = sclk & ~sclkPrev & clear;
    ctrl.latchEn = strobe;
  end

  // R1: a single sclk rise yields one shift, never two in a row
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> !ctrl.shiftEn);

endmodule

// File: rtl/slr_datapath.sv
module slr_datapath
  import slr_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  slr_ctrl_t     ctrl,
  input  logic          sdi,
  input  logic          outOff,
  input  logic [CH-1:0] chanFault,
  input  logic          allFault,
  output logic [CH-1:0] drive,
  output logic          sdo
);
  localparam int LAST = CH - 1;

  logic [CH-1:0] shiftReg;
  logic [CH-1:0] latchReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (ctrl.clrLoad)    shiftReg <= '0;
    else if (ctrl.shiftEn)    shiftReg <= {shiftReg[LAST-1:0], sdi};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchReg <= '0;
    else if (ctrl.latchEn) latchReg <= shiftReg;
  end

  assign sdo = shiftReg[LAST];

  // Per-channel output gating
  for (genvar i = 0; i < CH; i++) begin : g_chan
    assign drive[i] = latchReg[i] & ~outOff & ~chanFault[i] & ~allFault;
  end

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.shiftEn && !ctrl.clrLoad) |=>
      (shiftReg == {$past(shiftReg[LAST-1:0]), $past(sdi)}));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> $stable(shiftReg));
  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrLoad |=> (shiftReg == '0));
  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.latchEn |=> (latchReg == $past(shiftReg)));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.latchEn |=> $stable(latchReg));

endmodule

// File: rtl/slr_top.sv
module slr_top
  import slr_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          clear,
  input  logic          strobe,
  input  logic          outOff,
  input  logic [CH-1:0] chanFault,
  input  logic          allFault,
  output logic [CH-1:0] drive,
  output logic          sdo
);
  slr_ctrl_t ctrl;

  slr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .clear(clear),
    .strobe(strobe), .ctrl(ctrl)
  );

  slr_datapath #(.CH(CH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sdi(sdi), .outOff(outOff),
    .chanFault(chanFault), .allFault(allFault), .drive(drive), .sdo(sdo)
  );

  // R6
  off_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outOff |-> (drive == '0));
  // R7
  fault_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((drive & chanFault) == '0) && (!allFault || drive == '0));

endmodule

// File: tb/sim_slr_top.sv
module sim_slr_top;
  logic clk = 0;
  logic rstN = 0;
  logic sclk = 0, sdi = 0, clear = 0, strobe = 0, outOff = 0, allFault = 0;
  logic [7:0] chanFault = '0;
  logic [7:0] drive;
  logic sdo;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [7:0] expShift = '0, expLatch = '0;

  always #5 clk = ~clk;

  slr_top u0 (.clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .clear(clear),
    .strobe(strobe), .outOff(outOff), .chanFault(chanFault),
    .allFault(allFault), .drive(drive), .sdo(sdo));

  function automatic logic [7:0] expDrive();
    return expLatch & ~chanFault & ~{8{outOff}} & ~{8{allFault}};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One serial bit: sclk high one clk, low one clk (R9 minimum spacing)
  task automatic sbit(input logic d, input logic c);
    @(negedge clk); sdi = d; clear = c; sclk = 1;
    @(negedge clk); sclk = 0; clear = 0;
    expShift = c ? 8'h00 : {expShift[6:0], d};
  endtask

  task automatic pulseStrobe();
    @(negedge clk); strobe = 1;
    @(negedge clk); strobe = 0;
    expLatch = expShift;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 drive in reset", drive, 8'h00);
    check("R8 sdo in reset", {7'b0, sdo}, 8'h00);
    sclk = 1;                       // high across release must not shift
    @(negedge clk); rstN = 1;
    @(negedge clk); sclk = 0;
    @(negedge clk);
    check("R1 no edge at reset release", {7'b0, sdo}, 8'h00);

    // Random patterns through shift, strobe, gating
    for (int it = 0; it < 24; it++) begin
      pat = 8'($urandom);
      for (int b = 7; b >= 0; b--) begin
        sbit(pat[b], 1'b0);
        // R2 / R9: sdo follows stage 7 at back-to-back rate
        check("R2 sdo stage7", {7'b0, sdo}, {7'b0, expShift[7]});
      end
      check("R2 cascade bit out", {7'b0, sdo}, {7'b0, pat[7]});
      pulseStrobe();
      check("R4 strobe load", drive, pat);
      outOff = 1'($urandom);
      chanFault = 8'($urandom);
      allFault = (($urandom % 4) == 0);
      #1;
      check("R6 R7 gating", drive, expDrive());
      @(negedge clk);
      outOff = 0; chanFault = '0; allFault = 0;
      #1;
      check("R6 drive restored", drive, expLatch);
    end

    // R5: shifting with strobe low leaves outputs
    pat = expLatch;
    for (int b = 0; b < 8; b++) sbit(~pat[b], 1'b0);
    check("R5 hold while strobe low", drive, pat);

    // R3: clear without serial edge has no effect
    @(negedge clk); clear = 1;
    repeat (3) @(negedge clk);
    clear = 0;
    check("R3 clear w/o edge sdo", {7'b0, sdo}, {7'b0, expShift[7]});
    pulseStrobe();
    check("R3 clear w/o edge chain", drive, expShift);

    // Make chain nonzero then clear at an edge
    for (int b = 0; b < 8; b++) sbit(1'b1, 1'b0);
    pulseStrobe();
    check("R4 all ones", drive, 8'hFF);
    sbit(1'b1, 1'b1);
    check("R3 clear at edge sdo", {7'b0, sdo}, 8'h00);
    check("R4 cleared not yet on drive", drive, 8'hFF);
    pulseStrobe();
    check("R4 cleared after strobe", drive, 8'h00);

    // R4: transparency with strobe held high
    @(negedge clk); strobe = 1;
    for (int b = 0; b < 6; b++) begin
      sbit(1'($urandom), 1'b0);
      @(negedge clk);
      check("R4 transparent follow", drive, expShift);
    end
    @(negedge clk); strobe = 0;
    expLatch = expShift;

    // R7: single channel fault
    chanFault = 8'h01 << 3;
    #1;
    check("R7 one channel off", drive, expDrive());
    chanFault = '0;

    // R8: asynchronous reset mid-run
    for (int b = 0; b < 8; b++) sbit(1'b1, 1'b0);
    pulseStrobe();
    #2; rstN = 0; #1;
    check("R8 async reset drive", drive, 8'h00);
    check("R8 async reset sdo", {7'b0, sdo}, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule